// File: doc/BRIEF.md
# Debug exception dispatch unit

This unit sits after the breakpoint and watchpoint match logic. It turns a qualified hit into at most one debug exception request per event. A pending watchpoint hit becomes a data-abort request. The request carries the address that hit and a flag saying whether the access was a write. A breakpoint event becomes a prefetch-abort request whose fault address is forced to zero.

Every request carries two more things. The first is the exception level it must be delivered to, which is the configured debug target level. The second is a flag that is set when that target level equals the level the core is running at. A breakpoint event raises nothing when an external debugger owns a breakpoint at the current PC. It also raises nothing when no CPU breakpoint is present there, so single-step events can share the same path without being reported as breakpoints.

The request is a registered pulse that lasts one cycle. When the unit raises a data abort, it pulses a clear strobe back to the source of the pending watchpoint indication. It ignores that indication for the cycle in which the strobe is high.

Top module: `dbg_exc_dispatch`

## Requirements
- R1: During and right after reset, exc_valid_o is 0, exc_kind_o is 0, exc_far_o is 0 and wp_clr_o is 0.
- R2: When wp_pend_i is 1 and wp_clr_o is 0 at a clock edge, the outputs after that edge are as follows: exc_valid_o=1, exc_kind_o=1 (data abort), exc_far_o=wp_addr_i and exc_wnr_o=wp_wnr_i.
- R3: A qualified breakpoint event produces exc_valid_o=1 and exc_kind_o=2 (prefetch abort) after the edge, with exc_far_o=0 and exc_wnr_o=0. An event is qualified when bp_evt_i=1, cpu_bp_i=1 and ext_bp_i=0, and no watchpoint is being taken.
- R4: exc_same_el_o is 1 exactly when tgt_el_i equals cur_el_i in the cycle the event is accepted.
- R5: exc_tgt_el_o equals the tgt_el_i value of the cycle the event is accepted, whatever cur_el_i is.
- R6: A breakpoint event with ext_bp_i=1 raises no exception (exc_kind_o stays 0).
- R7: A breakpoint event with cpu_bp_i=0 raises no exception.
- R8: wp_clr_o is 1 in exactly the cycles where a data abort is output. A wp_pend_i that is still high during that cycle does not raise a second data abort.
- R9: When a watchpoint and a qualified breakpoint are accepted at the same edge, the data abort comes first. The prefetch abort follows at the next edge at which no watchpoint is taken, carrying the same-level flag and target level captured with the breakpoint.
- R10: A breakpoint event that arrives while another breakpoint is deferred is merged into it: only one prefetch abort results.
- R11: In any cycle without an accepted event, exc_valid_o, exc_kind_o, exc_wnr_o, exc_far_o and exc_tgt_el_o are all 0, so each request is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_pend_i | input | 1 | Watchpoint hit pending; held until wp_clr_o is seen |
| wp_addr_i | input | AW | Address of the access that hit |
| wp_wnr_i | input | 1 | 1 if the access was a write |
| bp_evt_i | input | 1 | Breakpoint or step debug event this cycle |
| ext_bp_i | input | 1 | External-debugger breakpoint present at current PC |
| cpu_bp_i | input | 1 | CPU breakpoint present at current PC |
| cur_el_i | input | ELW | Current exception level |
| tgt_el_i | input | ELW | Configured debug target exception level |
| exc_valid_o | output | 1 | Exception request pulse |
| exc_kind_o | output | 2 | 0 none, 1 data abort, 2 prefetch abort |
| exc_same_el_o | output | 1 | Syndrome flag: target level equals current level |
| exc_wnr_o | output | 1 | Syndrome write-not-read bit |
| exc_far_o | output | AW | Fault address |
| exc_tgt_el_o | output | ELW | Level the exception is delivered to |
| wp_clr_o | output | 1 | Clears the pending watchpoint indication |

## Verification
The bench holds wp_pend_i high through the clear cycle. A design that ignores its own clear strobe would report the same watchpoint twice. It sends a watchpoint and a breakpoint together and then changes the exception levels. A design that drops the deferred breakpoint, or rebuilds its syndrome from the later levels, gives a missing or wrong prefetch abort. Breakpoints owned by the external debugger, step events with no CPU breakpoint and stale write flags and addresses on breakpoints are all applied. Leaking any of them would show up as a spurious request, a nonzero fault address or a set write bit.

// File: rtl/dbg_exc_dispatch.sv
module dbg_exc_dispatch #(
  parameter int AW  = 48,
  parameter int ELW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wp_pend_i,
  input  logic [AW-1:0]  wp_addr_i,
  input  logic           wp_wnr_i,
  input  logic           bp_evt_i,
  input  logic           ext_bp_i,
  input  logic           cpu_bp_i,
  input  logic [ELW-1:0] cur_el_i,
  input  logic [ELW-1:0] tgt_el_i,
  output logic           exc_valid_o,
  output logic [1:0]     exc_kind_o,
  output logic           exc_same_el_o,
  output logic           exc_wnr_o,
  output logic [AW-1:0]  exc_far_o,
  output logic [ELW-1:0] exc_tgt_el_o,
  output logic           wp_clr_o
);
  localparam logic [1:0] KIND_NONE = 2'd0;
  localparam logic [1:0] KIND_DABT = 2'd1;
  localparam logic [1:0] KIND_PABT = 2'd2;

  logic           bp_hold_q;
  logic           hold_same_q;
  logic [ELW-1:0] hold_tgt_q;

  wire wp_take = wp_pend_i & ~wp_clr_o;
  wire bp_ok   = bp_evt_i & cpu_bp_i & ~ext_bp_i;
  wire same_now = (tgt_el_i == cur_el_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid_o   <= 1'b0;
      exc_kind_o    <= KIND_NONE;
      exc_same_el_o <= 1'b0;
      exc_wnr_o     <= 1'b0;
      exc_far_o     <= '0;
      exc_tgt_el_o  <= '0;
      wp_clr_o      <= 1'b0;
      bp_hold_q     <= 1'b0;
      hold_same_q   <= 1'b0;
      hold_tgt_q    <= '0;
    end else begin
      exc_valid_o   <= 1'b0;
      exc_kind_o    <= KIND_NONE;
      exc_same_el_o <= 1'b0;
      exc_wnr_o     <= 1'b0;
      exc_far_o     <= '0;
      exc_tgt_el_o  <= '0;
      wp_clr_o      <= 1'b0;
      if (wp_take) begin
        exc_valid_o   <= 1'b1;
        exc_kind_o    <= KIND_DABT;
        exc_same_el_o <= same_now;
        exc_wnr_o     <= wp_wnr_i;
        exc_far_o     <= wp_addr_i;
        exc_tgt_el_o  <= tgt_el_i;
        wp_clr_o      <= 1'b1;
        if (bp_ok && !bp_hold_q) begin
          bp_hold_q   <= 1'b1;
          hold_same_q <= same_now;
          hold_tgt_q  <= tgt_el_i;
        end
      end else if (bp_hold_q) begin
        exc_valid_o   <= 1'b1;
        exc_kind_o    <= KIND_PABT;
        exc_same_el_o <= hold_same_q;
        exc_tgt_el_o  <= hold_tgt_q;
        bp_hold_q     <= 1'b0;
      end else if (bp_ok) begin
        exc_valid_o   <= 1'b1;
        exc_kind_o    <= KIND_PABT;
        exc_same_el_o <= same_now;
        exc_tgt_el_o  <= tgt_el_i;
      end
    end
  end
endmodule

// File: rtl/dbg_exc_dispatch_chk.sv
module dbg_exc_dispatch_chk #(
  parameter int AW  = 48,
  parameter int ELW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wp_pend_i,
  input logic           bp_evt_i,
  input logic           ext_bp_i,
  input logic           cpu_bp_i,
  input logic [ELW-1:0] cur_el_i,
  input logic [ELW-1:0] tgt_el_i,
  input logic           exc_valid_o,
  input logic [1:0]     exc_kind_o,
  input logic           exc_same_el_o,
  input logic [AW-1:0]  exc_far_o,
  input logic           wp_clr_o,
  input logic           bp_hold_q
);
  p_wp_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_pend_i && !wp_clr_o) |=> (exc_valid_o && exc_kind_o == 2'd1));

  p_far_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_kind_o == 2'd2) |-> (exc_far_o == '0));

  p_same_el_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_pend_i && !wp_clr_o) |=> (exc_same_el_o == ($past(tgt_el_i) == $past(cur_el_i))));

  p_ext_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_evt_i && ext_bp_i && !wp_pend_i && !bp_hold_q) |=> !exc_valid_o);

  p_no_cpu_bp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_evt_i && !cpu_bp_i && !wp_pend_i && !bp_hold_q) |=> !exc_valid_o);

  p_clr_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_clr_o |=> !wp_clr_o);

  p_clr_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_clr_o == (exc_kind_o == 2'd1));

  p_pulse_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o == (exc_kind_o != 2'd0));
endmodule

bind dbg_exc_dispatch dbg_exc_dispatch_chk #(.AW(AW), .ELW(ELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_pend_i(wp_pend_i), .bp_evt_i(bp_evt_i),
  .ext_bp_i(ext_bp_i), .cpu_bp_i(cpu_bp_i), .cur_el_i(cur_el_i),
  .tgt_el_i(tgt_el_i), .exc_valid_o(exc_valid_o), .exc_kind_o(exc_kind_o),
  .exc_same_el_o(exc_same_el_o), .exc_far_o(exc_far_o), .wp_clr_o(wp_clr_o),
  .bp_hold_q(bp_hold_q)
);

// File: tb/dbg_exc_dispatch_test.sv
module dbg_exc_dispatch_test;
  localparam int AW = 16;
  localparam int ELW = 2;
  localparam int NV = 8;

  // [46]wp [45]bp [44]ext [43]cpu [42:41]cur [40:39]tgt [38]wnr [37:22]addr
  // [21:20]kind [19]same [18:17]tgt [16]wnr [15:0]far
  localparam logic [46:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b0,2'd1,2'd1,1'b1,16'h1234, 2'd1,1'b1,2'd1,1'b1,16'h1234},
    {1'b1,1'b0,1'b0,1'b0,2'd0,2'd1,1'b0,16'hBEEF, 2'd1,1'b0,2'd1,1'b0,16'hBEEF},
    {1'b0,1'b1,1'b0,1'b1,2'd1,2'd2,1'b0,16'h5555, 2'd2,1'b0,2'd2,1'b0,16'h0000},
    {1'b0,1'b1,1'b0,1'b1,2'd2,2'd2,1'b0,16'h0F0F, 2'd2,1'b1,2'd2,1'b0,16'h0000},
    {1'b0,1'b1,1'b1,1'b1,2'd1,2'd1,1'b0,16'h7777, 2'd0,1'b0,2'd0,1'b0,16'h0000},
    {1'b0,1'b1,1'b0,1'b0,2'd1,2'd1,1'b0,16'h8888, 2'd0,1'b0,2'd0,1'b0,16'h0000},
    {1'b0,1'b0,1'b0,1'b1,2'd0,2'd0,1'b1,16'h9999, 2'd0,1'b0,2'd0,1'b0,16'h0000},
    {1'b0,1'b1,1'b0,1'b1,2'd3,2'd3,1'b1,16'hFFFF, 2'd2,1'b1,2'd3,1'b0,16'h0000}
  };
  localparam string VTAG [NV] = '{"R2 R4", "R4 R5", "R3 R5", "R3 R4", "R6", "R7", "R11", "R3"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_pend_i = 1'b0, wp_wnr_i = 1'b0, bp_evt_i = 1'b0, ext_bp_i = 1'b0, cpu_bp_i = 1'b0;
  logic [AW-1:0] wp_addr_i = '0;
  logic [ELW-1:0] cur_el_i = '0, tgt_el_i = '0;
  logic exc_valid_o, exc_same_el_o, exc_wnr_o, wp_clr_o;
  logic [1:0] exc_kind_o;
  logic [AW-1:0] exc_far_o;
  logic [ELW-1:0] exc_tgt_el_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dbg_exc_dispatch #(.AW(AW), .ELW(ELW)) uut (
    .clk(clk), .rst_n(rst_n), .wp_pend_i(wp_pend_i), .wp_addr_i(wp_addr_i),
    .wp_wnr_i(wp_wnr_i), .bp_evt_i(bp_evt_i), .ext_bp_i(ext_bp_i), .cpu_bp_i(cpu_bp_i),
    .cur_el_i(cur_el_i), .tgt_el_i(tgt_el_i), .exc_valid_o(exc_valid_o),
    .exc_kind_o(exc_kind_o), .exc_same_el_o(exc_same_el_o), .exc_wnr_o(exc_wnr_o),
    .exc_far_o(exc_far_o), .exc_tgt_el_o(exc_tgt_el_o), .wp_clr_o(wp_clr_o)
  );

  task automatic expect_out(string tag, logic [1:0] k, logic s, logic [ELW-1:0] t,
                            logic w, logic [AW-1:0] f);
    logic v = (k != 2'd0);
    logic c = (k == 2'd1);
    checks++;
    if (exc_valid_o !== v || exc_kind_o !== k || exc_same_el_o !== s || exc_tgt_el_o !== t ||
        exc_wnr_o !== w || exc_far_o !== f || wp_clr_o !== c) begin
      fails++;
      $display("FAIL %s: got v=%b k=%0d s=%b t=%0d w=%b far=%h clr=%b, exp v=%b k=%0d s=%b t=%0d w=%b far=%h clr=%b",
               tag, exc_valid_o, exc_kind_o, exc_same_el_o, exc_tgt_el_o, exc_wnr_o, exc_far_o,
               wp_clr_o, v, k, s, t, w, f, c);
    end
  endtask

  task automatic idle_in();
    wp_pend_i = 0; bp_evt_i = 0; ext_bp_i = 0; cpu_bp_i = 0; wp_wnr_i = 0;
    wp_addr_i = '0; cur_el_i = '0; tgt_el_i = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    expect_out("R1 reset", 2'd0, 0, 0, 0, '0);
    @(negedge clk); rst_n = 1;
    step();
    expect_out("R1 after reset", 2'd0, 0, 0, 0, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wp_pend_i, bp_evt_i, ext_bp_i, cpu_bp_i, cur_el_i, tgt_el_i, wp_wnr_i, wp_addr_i} = VEC[i][46:22];
      step();
      expect_out(VTAG[i], VEC[i][21:20], VEC[i][19], VEC[i][18:17], VEC[i][16], VEC[i][15:0]);
      @(negedge clk); idle_in();
      step();
      expect_out("R11 idle", 2'd0, 0, 0, 0, '0);
    end

    // R8: pending held through the clear cycle is not raised again
    @(negedge clk); wp_pend_i = 1; wp_addr_i = 16'hA5A5; wp_wnr_i = 1; cur_el_i = 1; tgt_el_i = 2;
    step();
    expect_out("R8 first", 2'd1, 0, 2, 1, 16'hA5A5);
    step();
    expect_out("R8 no repeat", 2'd0, 0, 0, 0, '0);
    @(negedge clk); idle_in(); step();

    // R9: simultaneous, watchpoint first, breakpoint keeps captured levels
    @(negedge clk); wp_pend_i = 1; bp_evt_i = 1; cpu_bp_i = 1; wp_addr_i = 16'h0042;
    cur_el_i = 1; tgt_el_i = 1;
    step();
    expect_out("R9 watchpoint first", 2'd1, 1, 1, 0, 16'h0042);
    @(negedge clk); bp_evt_i = 0; cpu_bp_i = 0; cur_el_i = 0; tgt_el_i = 3;
    step();
    expect_out("R9 deferred breakpoint", 2'd2, 1, 1, 0, '0);
    @(negedge clk); idle_in(); step();
    expect_out("R9 then idle", 2'd0, 0, 0, 0, '0);

    // R10: a breakpoint arriving while one is deferred is merged
    @(negedge clk); wp_pend_i = 1; bp_evt_i = 1; cpu_bp_i = 1; cur_el_i = 2; tgt_el_i = 2;
    step();
    expect_out("R10 watchpoint", 2'd1, 1, 2, 0, '0);
    step();
    expect_out("R10 single prefetch", 2'd2, 1, 2, 0, '0);
    @(negedge clk); idle_in(); step();
    expect_out("R10 merged", 2'd0, 0, 0, 0, '0);

    // R1: reset in the middle of a deferred breakpoint
    @(negedge clk); wp_pend_i = 1; bp_evt_i = 1; cpu_bp_i = 1;
    step();
    @(negedge clk); idle_in(); rst_n = 0; step();
    expect_out("R1 mid reset", 2'd0, 0, 0, 0, '0);
    @(negedge clk); rst_n = 1; step();
    expect_out("R1 hold cleared", 2'd0, 0, 0, 0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule